// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block generates the pixel and line counts for a progressive-scan display and derives from them an active-video flag, horizontal and vertical sync, and a one-clock prefetch strobe at a programmable point on each line. Software programs every boundary of the raster over a simple write-only register bus. Each boundary register holds the last count of its region, so a region that spans N counts is written as N-1.

A control register starts and stops the counters and separately gates screen refresh. A sync control register sets the polarity of each sync, can force either sync or both to their inactive level for power-saving blanking, and carries a sync-on-RGB flag to the output stage. A display control bit blanks the video regardless of position. Geometry written while the raster runs is held in a shadow copy and moves into use only at the frame boundary, so a half-finished update never reaches the counters.

Top module: `disp_timing_gen`

## Requirements
- R1: The horizontal count runs from 0 up to the horizontal last-count register (address 3) and then returns to 0. The vertical count advances by one on each horizontal wrap and returns to 0 after the vertical last-count register (address 7) is reached.
- R2: `video_on` is high exactly when the horizontal count is at most the horizontal active-last register (address 4) and the vertical count is at most the vertical active-last register (address 8), while the generator and refresh are both enabled and the display is not blanked.
- R3: Before polarity is applied, hsync is active while the horizontal count lies between the sync-first register (address 5) and the sync-last register (address 6), both inclusive. Vsync does the same with the vertical count and addresses 9 and 10.
- R4: `prefetch_stb` is high for exactly the one clock in which the horizontal count equals the prefetch position register (address 11).
- R5: Control register (address 0) bit 0 enables the generator. While it is clear, both counts hold at 0, `video_on` and `prefetch_stb` are low, and each sync sits at its inactive level.
- R6: Control register bit 1 enables refresh. While it is clear, `video_on` is low, and the counts, syncs and strobe continue to run.
- R7: Sync control register (address 1) bit 3 inverts hsync and bit 4 inverts vsync.
- R8: Sync control bit 1 forces both syncs off, bit 5 forces hsync off and bit 6 forces vsync off. A forced-off sync is driven to its inactive level, which is the value of its inversion bit.
- R9: Sync control bit 0 appears directly on `sync_on_rgb`.
- R10: Display control register (address 2) bit 1 forces `video_on` low. The counts and syncs are not affected.
- R11: Geometry registers (addresses 3 to 11) are written to a shadow copy. The shadow copy moves into use on the clock in which both counts wrap together. While the generator is disabled, it moves into use on every clock. Control, sync control and display control writes take effect on the next clock.
- R12: After reset, all registers are zero, both counts are 0, and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CW | Register write data |
| h_count | output | CW | Horizontal pixel count |
| v_count | output | CW | Vertical line count |
| video_on | output | 1 | Active video flag |
| hsync | output | 1 | Horizontal sync after polarity and forcing |
| vsync | output | 1 | Vertical sync after polarity and forcing |
| prefetch_stb | output | 1 | Per-line prefetch strobe |
| sync_on_rgb | output | 1 | Sync-on-RGB flag to the output stage |

## Verification
The critical collision occurs when the prefetch position is set to the horizontal last count. The strobe then fires in the same cycle as the line wrap. On the final line, that cycle is also the frame wrap, in which the shadow geometry moves into use. The bench writes that prefetch position, together with a new line length, in the middle of a frame. It then checks every output on every cycle against an arithmetic model. That model keeps the old geometry until both counts wrap, so a strobe or wrap that follows the new values one frame too early or too late is flagged.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int NGEO = 9;

    localparam logic [3:0] ADDR_CTRL = 4'd0;
    localparam logic [3:0] ADDR_SYNC = 4'd1;
    localparam logic [3:0] ADDR_DISP = 4'd2;
    localparam logic [3:0] ADDR_GEO0 = 4'd3;

    // geometry slots, relative to ADDR_GEO0
    localparam int G_H_LAST = 0;
    localparam int G_H_ACT  = 1;
    localparam int G_HS_ON  = 2;
    localparam int G_HS_OFF = 3;
    localparam int G_V_LAST = 4;
    localparam int G_V_ACT  = 5;
    localparam int G_VS_ON  = 6;
    localparam int G_VS_OFF = 7;
    localparam int G_PF_POS = 8;

    typedef struct packed {
        logic rgb;
        logic all_off;
        logic h_inv;
        logic v_inv;
        logic h_off;
        logic v_off;
    } sync_ctl_t;
endpackage

// File: rtl/dtg_regfile.sv
module dtg_regfile
    import dtg_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [3:0]                 wr_addr,
    input  logic [CW-1:0]              wr_data,
    input  logic                       frame_end,
    output logic                       gen_en,
    output logic                       refresh_en,
    output logic                       disp_off,
    output sync_ctl_t                  sync_ctl,
    output logic [NGEO-1:0][CW-1:0]    geo_act
);
    typedef struct packed {
        logic                    en;
        logic                    refresh;
        logic                    disp_off;
        sync_ctl_t               sync;
        logic [NGEO-1:0][CW-1:0] shadow;
        logic [NGEO-1:0][CW-1:0] act;
    } regs_t;

    regs_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: begin
                    reg_d.en      = wr_data[0];
                    reg_d.refresh = wr_data[1];
                end
                ADDR_SYNC: begin
                    reg_d.sync.rgb     = wr_data[0];
                    reg_d.sync.all_off = wr_data[1];
                    reg_d.sync.h_inv   = wr_data[3];
                    reg_d.sync.v_inv   = wr_data[4];
                    reg_d.sync.h_off   = wr_data[5];
                    reg_d.sync.v_off   = wr_data[6];
                end
                ADDR_DISP: reg_d.disp_off = wr_data[1];
                default: begin
                    for (int i = 0; i < NGEO; i++) begin
                        if (wr_addr == ADDR_GEO0 + 4'(i))
                            reg_d.shadow[i] = wr_data;
                    end
                end
            endcase
        end
        // geometry in use changes only when idle or at the frame boundary
        if (!reg_q.en || frame_end)
            reg_d.act = reg_q.shadow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign gen_en     = reg_q.en;
    assign refresh_en = reg_q.refresh;
    assign disp_off   = reg_q.disp_off;
    assign sync_ctl   = reg_q.sync;
    assign geo_act    = reg_q.act;
endmodule

// File: rtl/dtg_raster.sv
module dtg_raster #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] h_last,
    input  logic [CW-1:0] v_last,
    output logic [CW-1:0] h_cnt,
    output logic [CW-1:0] v_cnt,
    output logic          frame_end
);
    typedef struct packed {
        logic [CW-1:0] h;
        logic [CW-1:0] v;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic line_end;

    assign line_end  = en && (cnt_q.h == h_last);
    assign frame_end = line_end && (cnt_q.v == v_last);

    always_comb begin
        cnt_d = cnt_q;
        if (!en) begin
            cnt_d = '0;
        end else if (line_end) begin
            cnt_d.h = '0;
            cnt_d.v = frame_end ? '0 : cnt_q.v + CW'(1);
        end else begin
            cnt_d.h = cnt_q.h + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign h_cnt = cnt_q.h;
    assign v_cnt = cnt_q.v;
endmodule

// File: rtl/dtg_shaper.sv
module dtg_shaper
    import dtg_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic                    en,
    input  logic                    refresh_en,
    input  logic                    disp_off,
    input  sync_ctl_t               sync_ctl,
    input  logic [NGEO-1:0][CW-1:0] geo,
    input  logic [CW-1:0]           h_cnt,
    input  logic [CW-1:0]           v_cnt,
    output logic                    video_on,
    output logic                    hsync,
    output logic                    vsync,
    output logic                    prefetch_stb,
    output logic                    sync_on_rgb
);
    logic in_h_act, in_v_act, hs_raw, vs_raw;

    always_comb begin
        in_h_act = h_cnt <= geo[G_H_ACT];
        in_v_act = v_cnt <= geo[G_V_ACT];
        hs_raw   = en && (h_cnt >= geo[G_HS_ON]) && (h_cnt <= geo[G_HS_OFF]);
        vs_raw   = en && (v_cnt >= geo[G_VS_ON]) && (v_cnt <= geo[G_VS_OFF]);
        video_on = en && refresh_en && !disp_off && in_h_act && in_v_act;
        hsync    = (hs_raw && !sync_ctl.all_off && !sync_ctl.h_off) ^ sync_ctl.h_inv;
        vsync    = (vs_raw && !sync_ctl.all_off && !sync_ctl.v_off) ^ sync_ctl.v_inv;
        prefetch_stb = en && (h_cnt == geo[G_PF_POS]);
        sync_on_rgb  = sync_ctl.rgb;
    end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] h_count,
    output logic [CW-1:0] v_count,
    output logic          video_on,
    output logic          hsync,
    output logic          vsync,
    output logic          prefetch_stb,
    output logic          sync_on_rgb
);
    logic                    gen_en, refresh_en, disp_off, frame_end;
    sync_ctl_t               sync_ctl;
    logic [NGEO-1:0][CW-1:0] geo_act;

    dtg_regfile #(.CW(CW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_end(frame_end), .gen_en(gen_en),
        .refresh_en(refresh_en), .disp_off(disp_off), .sync_ctl(sync_ctl),
        .geo_act(geo_act)
    );

    dtg_raster #(.CW(CW)) raster_i (
        .clk(clk), .rst_n(rst_n), .en(gen_en),
        .h_last(geo_act[G_H_LAST]), .v_last(geo_act[G_V_LAST]),
        .h_cnt(h_count), .v_cnt(v_count), .frame_end(frame_end)
    );

    dtg_shaper #(.CW(CW)) shaper_i (
        .en(gen_en), .refresh_en(refresh_en), .disp_off(disp_off),
        .sync_ctl(sync_ctl), .geo(geo_act), .h_cnt(h_count), .v_cnt(v_count),
        .video_on(video_on), .hsync(hsync), .vsync(vsync),
        .prefetch_stb(prefetch_stb), .sync_on_rgb(sync_on_rgb)
    );
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
    import dtg_pkg::*;
#(
    parameter int CW = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    gen_en,
    input logic                    frame_end,
    input logic [CW-1:0]           h_count,
    input logic [CW-1:0]           v_count,
    input logic                    video_on,
    input logic                    prefetch_stb,
    input logic [NGEO-1:0][CW-1:0] geo
);
    // R5: disabled generator parks both counts at zero
    a_r5_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> (h_count == '0 && v_count == '0));

    // R1: counting step inside a line
    a_r1_h_step: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && h_count != geo[G_H_LAST]) |=> (h_count == $past(h_count) + CW'(1)));

    // R1: wrap after the last count
    a_r1_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && h_count == geo[G_H_LAST]) |=> (h_count == '0));

    // R2: video only inside the active region
    a_r2_video_region: assert property (@(posedge clk) disable iff (!rst_n)
        video_on |-> (h_count <= geo[G_H_ACT] && v_count <= geo[G_V_ACT]));

    // R4: strobe lasts one clock
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        (prefetch_stb && !frame_end && geo[G_H_LAST] != '0) |=> !prefetch_stb);

    // R11: geometry in use is frozen mid-frame
    a_r11_geo_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && !frame_end) |=> $stable(geo));
endmodule

bind disp_timing_gen dtg_checker #(.CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .frame_end(frame_end),
    .h_count(h_count), .v_count(v_count), .video_on(video_on),
    .prefetch_stb(prefetch_stb), .geo(geo_act)
);

// File: tb/disp_timing_gen_tb.sv
module disp_timing_gen_tb_top;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [CW-1:0] h_count, v_count;
    logic          video_on, hsync, vsync, prefetch_stb, sync_on_rgb;

    always #2 clk = ~clk;

    disp_timing_gen #(.CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .h_count(h_count), .v_count(v_count),
        .video_on(video_on), .hsync(hsync), .vsync(vsync),
        .prefetch_stb(prefetch_stb), .sync_on_rgb(sync_on_rgb)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int m_h = 0, m_v = 0;
    int sh[9], ac[9];
    bit m_en, m_ref, m_doff, m_rgb, m_all, m_hi, m_vi, m_ho, m_vo;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (h=%0d v=%0d)", tag, act, exp, m_h, m_v);
        end
    endtask

    task automatic check_all();
        int e_de, e_hs, e_vs, e_pf;
        e_de = int'(m_en && m_ref && !m_doff && m_h <= ac[1] && m_v <= ac[5]);
        e_hs = int'((m_en && m_h >= ac[2] && m_h <= ac[3] && !m_all && !m_ho) ^ m_hi);
        e_vs = int'((m_en && m_v >= ac[6] && m_v <= ac[7] && !m_all && !m_vo) ^ m_vi);
        e_pf = int'(m_en && m_h == ac[8]);
        chk("R1/R5/R11 h_count", int'(h_count), m_h);
        chk("R1/R5/R11 v_count", int'(v_count), m_v);
        chk("R2/R6/R10 video_on", int'(video_on), e_de);
        chk("R3/R7/R8 hsync", int'(hsync), e_hs);
        chk("R3/R7/R8 vsync", int'(vsync), e_vs);
        chk("R4 prefetch_stb", int'(prefetch_stb), e_pf);
        chk("R9 sync_on_rgb", int'(sync_on_rgb), int'(m_rgb));
    endtask

    task automatic cycle(bit we, int addr, int data);
        wr_en   = we;
        wr_addr = 4'(addr);
        wr_data = CW'(data);
        // model clock edge, using register values before this write
        if (!m_en) begin
            m_h = 0; m_v = 0; ac = sh;
        end else if (m_h == ac[0]) begin
            m_h = 0;
            if (m_v == ac[4]) begin m_v = 0; ac = sh; end
            else m_v++;
        end else begin
            m_h++;
        end
        if (we) begin
            if (addr == 0) begin m_en = data[0]; m_ref = data[1]; end
            else if (addr == 1) begin
                m_rgb = data[0]; m_all = data[1]; m_hi = data[3];
                m_vi = data[4]; m_ho = data[5]; m_vo = data[6];
            end
            else if (addr == 2) m_doff = data[1];
            else if (addr >= 3 && addr <= 11) sh[addr-3] = data;
        end
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle(0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 9; i++) begin sh[i] = 0; ac[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        chk("R12 h_count", int'(h_count), 0);
        chk("R12 v_count", int'(v_count), 0);
        chk("R12 video_on", int'(video_on), 0);
        chk("R12 hsync", int'(hsync), 0);
        chk("R12 vsync", int'(vsync), 0);
        chk("R12 prefetch_stb", int'(prefetch_stb), 0);
        chk("R12 sync_on_rgb", int'(sync_on_rgb), 0);
        rst_n = 1'b1;

        // small raster: 10 x 6 counts
        cycle(1, 3, 9);  cycle(1, 4, 5);  cycle(1, 5, 6);
        cycle(1, 6, 7);  cycle(1, 7, 5);  cycle(1, 8, 3);
        cycle(1, 9, 4);  cycle(1, 10, 4); cycle(1, 11, 8);
        idle(3);                        // R5: still parked
        cycle(1, 0, 3);                 // R1: enable with refresh
        idle(130);
        cycle(1, 1, 'h18);              // R7: invert both
        idle(60);
        cycle(1, 1, 'h28);              // R8: hsync off, inverted
        idle(60);
        cycle(1, 1, 'h40);              // R8: vsync off
        idle(60);
        cycle(1, 1, 'h1b);              // R8 all off, R9 rgb flag
        idle(60);
        cycle(1, 1, 0);
        cycle(1, 2, 2);                 // R10: display off
        idle(30);
        cycle(1, 2, 0);
        cycle(1, 0, 1);                 // R6: refresh off
        idle(30);
        cycle(1, 0, 3);
        idle(17);
        // R11 and R4: strobe on the wrap cycle plus a longer line, mid-frame
        cycle(1, 11, 9);
        cycle(1, 3, 11);
        cycle(1, 4, 7);
        idle(130);
        cycle(1, 11, 11);
        idle(200);
        cycle(1, 1, 'h18);
        cycle(1, 0, 0);                 // R5: disable, syncs at inactive level
        idle(10);
        cycle(1, 3, 7);                 // R11: loaded at once while idle
        cycle(1, 11, 3);
        idle(5);
        cycle(1, 0, 3);
        idle(120);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule